// File: doc/BRIEF.md
# Debug Emulator-Mode Exception Controller

This block keeps track of whether a processor core is running its debug service routine (emulator mode) and decides which exception, if any, to take at each instruction boundary. A breakpoint trigger that is set up to raise a debug interrupt is served before any level on the encoded interrupt-priority input. When the debug interrupt is taken, the block sets its emulator-mode flag and shows the processor-status code 0xD for a fixed number of cycles.

Normal interrupts may nest inside the debug routine. When any exception is taken, the live emulator-mode value is copied into the FS1 bit of the composed exception frame header word, and the flag is then cleared. When the core executes a return-from-exception, it hands the restored header word back to the block. If FS1 in that word is set, emulator mode is entered again and the 0xD status is repeated. Otherwise the block reports a plain return.

The core performs the stacking and memory traffic itself. This block supplies only the request, the vector, the header word and the status code.

Top module: `emu_exc_ctl`

## Requirements
- R1: Reset clears all state. After reset, `emuMode`=0, `excReq`=0, `excType`=0, `pst`=0x0 and `frameWord`=0. This holds even when reset arrives while emulator mode is active.
- R2: At an instruction-boundary cycle with no RTE, a breakpoint trigger outside emulator mode is taken as a debug exception for any `ipl` value. On the next cycle, `excReq`=1, `excType`=1 (debug) and `excVector`=12.
- R3: Taking the debug exception sets `emuMode` on the next cycle. From that same cycle, `pst` reads 0xD for exactly `PST_HOLD` (3) cycles and then returns to the idle code 0x0.
- R4: Requests are sampled only in cycles where `instBoundary`=1. A trigger or a nonzero `ipl` in any other cycle gives no `excReq` and leaves `emuMode` and `pst` unchanged.
- R5: When a normal interrupt is taken in emulator mode, `frameWord` bit 17 (FS1) becomes 1 and `emuMode` becomes 0 on the next cycle.
- R6: Header layout: bits 31:28 hold the format value 4, bits 27:26 hold 0, bits 25:18 hold the vector, bit 17 holds the saved emulator-mode bit, bit 16 holds 0, and bits 15:0 hold `statusReg` as sampled at the taking edge.
- R7: An RTE whose `rteFrame` bit 17 is 1 sets `emuMode` on the next cycle and starts the same 3-cycle 0xD status as R3.
- R8: An RTE whose `rteFrame` bit 17 is 0 leaves `emuMode` at 0 and shows `pst`=0x7 for one cycle. This code replaces any 0xD hold still running.
- R9: A breakpoint trigger at a boundary while `emuMode`=1 and `ipl`=0 is ignored. There is no `excReq`, and `emuMode` stays 1.
- R10: A nonzero `ipl` at a boundary with no debug hit is taken as a normal exception. `excType`=2 and `excVector`=24+`ipl`. Outside emulator mode, FS1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bkptTrig | input | 1 | Breakpoint trigger configured for debug interrupt |
| ipl | input | 3 | Encoded interrupt priority level, 0 = none |
| instBoundary | input | 1 | Instruction-boundary sample strobe |
| rteStrobe | input | 1 | Return-from-exception is being executed |
| rteFrame | input | 32 | Header word restored from the stack on RTE |
| statusReg | input | 16 | Current status register value |
| excReq | output | 1 | One-cycle exception request |
| excType | output | 2 | 0 none, 1 debug, 2 normal interrupt |
| excVector | output | 8 | Vector of the last exception taken |
| frameWord | output | 32 | Header word of the last exception taken |
| emuMode | output | 1 | Emulator-mode flag |
| pst | output | 4 | Processor-status code |

## Verification
The request path is driven with the following cases:
- a lone interrupt level;
- a trigger and a level off the boundary strobe;
- a trigger and the top level together;
- a trigger while already in emulator mode;
- a level arriving inside the debug routine.

These cases separate priority, sampling and recursion blocking. RTE is driven with FS1 set and with FS1 clear, including a clear-FS1 return that cuts a running 0xD hold short. This separates re-entry from plain return and shows that the newer code overrides the hold. Directed cases then check the full header word against a non-trivial status value, both outside and inside emulator mode, and check a reset taken while in emulator mode.

// File: rtl/emu_pkg.sv
package emu_pkg;
  localparam int IPL_W = 3;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_DEBUG = 2'd1,
    EXC_IRQ   = 2'd2
  } excKind_e;

  localparam logic [3:0] PST_IDLE = 4'h0;
  localparam logic [3:0] PST_EMU  = 4'hD;
  localparam logic [3:0] PST_RET  = 4'h7;

  localparam int FS1_BIT = 17;

  typedef struct packed {
    logic             takeDebug;
    logic             takeIrq;
    logic             savedEmu;
    logic [IPL_W-1:0] level;
  } ctlStrobes_t;
endpackage

// File: rtl/emu_ctl.sv
module emu_ctl
  import emu_pkg::*;
#(
  parameter int PST_HOLD = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bkptTrig,
  input  logic [IPL_W-1:0] ipl,
  input  logic             instBoundary,
  input  logic             rteStrobe,
  input  logic             rteFs1,
  output ctlStrobes_t      strobes,
  output logic             excReq,
  output logic [1:0]       excType,
  output logic             emuMode,
  output logic [3:0]       pst
);
  localparam int CNT_W = (PST_HOLD > 1) ? $clog2(PST_HOLD) : 1;
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(PST_HOLD - 1);

  logic             dbgHit;
  logic             irqHit;
  logic             reEnter;
  logic [CNT_W-1:0] holdCnt;

  always_comb begin
    dbgHit  = !rteStrobe && instBoundary && bkptTrig && !emuMode;
    irqHit  = !rteStrobe && instBoundary && (ipl != '0) && !dbgHit;
    reEnter = rteStrobe && rteFs1;
    strobes = '{takeDebug: dbgHit, takeIrq: irqHit, savedEmu: emuMode, level: ipl};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excReq  <= 1'b0;
      excType <= EXC_NONE;
      emuMode <= 1'b0;
    end else begin
      excReq  <= dbgHit || irqHit;
      excType <= dbgHit ? EXC_DEBUG : (irqHit ? EXC_IRQ : EXC_NONE);
      if (rteStrobe)   emuMode <= rteFs1;
      else if (dbgHit) emuMode <= 1'b1;
      else if (irqHit) emuMode <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pst     <= PST_IDLE;
      holdCnt <= '0;
    end else if (dbgHit || reEnter) begin
      pst     <= PST_EMU;
      holdCnt <= HOLD_LOAD;
    end else if (rteStrobe) begin
      pst     <= PST_RET;
      holdCnt <= '0;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end else begin
      pst <= PST_IDLE;
    end
  end
endmodule

// File: rtl/emu_dp.sv
module emu_dp
  import emu_pkg::*;
#(
  parameter logic [3:0] FRAME_FMT = 4'h4,
  parameter logic [7:0] DBG_VEC   = 8'd12,
  parameter logic [7:0] AUTO_BASE = 8'd24
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic [15:0] statusReg,
  output logic [7:0]  excVector,
  output logic [31:0] frameWord
);
  logic [7:0]  nextVec;
  logic [31:0] nextFrame;

  always_comb begin
    nextVec   = strobes.takeDebug ? DBG_VEC : AUTO_BASE + 8'(strobes.level);
    nextFrame = {FRAME_FMT, 2'b00, nextVec, strobes.savedEmu, 1'b0, statusReg};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excVector <= '0;
      frameWord <= '0;
    end else if (strobes.takeDebug || strobes.takeIrq) begin
      excVector <= nextVec;
      frameWord <= nextFrame;
    end
  end
endmodule

// File: rtl/emu_exc_ctl.sv
module emu_exc_ctl
  import emu_pkg::*;
#(
  parameter int         PST_HOLD  = 3,
  parameter logic [3:0] FRAME_FMT = 4'h4,
  parameter logic [7:0] DBG_VEC   = 8'd12,
  parameter logic [7:0] AUTO_BASE = 8'd24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bkptTrig,
  input  logic [2:0]  ipl,
  input  logic        instBoundary,
  input  logic        rteStrobe,
  input  logic [31:0] rteFrame,
  input  logic [15:0] statusReg,
  output logic        excReq,
  output logic [1:0]  excType,
  output logic [7:0]  excVector,
  output logic [31:0] frameWord,
  output logic        emuMode,
  output logic [3:0]  pst
);
  ctlStrobes_t strobes;

  emu_ctl #(.PST_HOLD(PST_HOLD)) u_ctl (
    .clk(clk), .rstN(rstN), .bkptTrig(bkptTrig), .ipl(ipl),
    .instBoundary(instBoundary), .rteStrobe(rteStrobe),
    .rteFs1(rteFrame[FS1_BIT]), .strobes(strobes), .excReq(excReq),
    .excType(excType), .emuMode(emuMode), .pst(pst)
  );

  emu_dp #(.FRAME_FMT(FRAME_FMT), .DBG_VEC(DBG_VEC), .AUTO_BASE(AUTO_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .statusReg(statusReg),
    .excVector(excVector), .frameWord(frameWord)
  );
endmodule

// File: rtl/emu_exc_chk.sv
module emu_exc_chk #(
  parameter logic [3:0] FRAME_FMT = 4'h4
) (
  input logic        clk,
  input logic        rstN,
  input logic        bkptTrig,
  input logic [2:0]  ipl,
  input logic        instBoundary,
  input logic        rteStrobe,
  input logic [31:0] rteFrame,
  input logic        excReq,
  input logic [1:0]  excType,
  input logic [7:0]  excVector,
  input logic [31:0] frameWord,
  input logic        emuMode,
  input logic [3:0]  pst
);
  AST_DEBUG_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (instBoundary && !rteStrobe && bkptTrig && !emuMode) |=> (excReq && excType == 2'd1)); // R2

  AST_EMU_ENTRY_PST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emuMode) |-> (pst == 4'hD)); // R3

  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!instBoundary) |=> !excReq); // R4

  AST_IRQ_SAVES_EMU: assert property (@(posedge clk) disable iff (!rstN)
    (instBoundary && !rteStrobe && ipl != 3'd0 && emuMode) |=> (!emuMode && frameWord[17])); // R5

  AST_FRAME_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (frameWord[31:28] == FRAME_FMT && frameWord[27:26] == 2'b00 &&
                frameWord[16] == 1'b0 && frameWord[25:18] == excVector)); // R6

  AST_RTE_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    rteStrobe |=> (emuMode == $past(rteFrame[17]))); // R7

  AST_RTE_PLAIN_PST: assert property (@(posedge clk) disable iff (!rstN)
    (rteStrobe && !rteFrame[17]) |=> (pst == 4'h7)); // R8

  AST_NO_RECURSE: assert property (@(posedge clk) disable iff (!rstN)
    (instBoundary && !rteStrobe && bkptTrig && emuMode && ipl == 3'd0) |=> (!excReq && emuMode)); // R9
endmodule

bind emu_exc_ctl emu_exc_chk #(.FRAME_FMT(FRAME_FMT)) u_chk (
  .clk(clk), .rstN(rstN), .bkptTrig(bkptTrig), .ipl(ipl),
  .instBoundary(instBoundary), .rteStrobe(rteStrobe), .rteFrame(rteFrame),
  .excReq(excReq), .excType(excType), .excVector(excVector),
  .frameWord(frameWord), .emuMode(emuMode), .pst(pst)
);

// File: tb/sim_emu_exc_ctl.sv
module sim_emu_exc_ctl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        bkptTrig;
  logic [2:0]  ipl;
  logic        instBoundary;
  logic        rteStrobe;
  logic [31:0] rteFrame;
  logic [15:0] statusReg;
  logic        excReq;
  logic [1:0]  excType;
  logic [7:0]  excVector;
  logic [31:0] frameWord;
  logic        emuMode;
  logic [3:0]  pst;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  emu_exc_ctl u0 (
    .clk(clk), .rstN(rstN), .bkptTrig(bkptTrig), .ipl(ipl),
    .instBoundary(instBoundary), .rteStrobe(rteStrobe), .rteFrame(rteFrame),
    .statusReg(statusReg), .excReq(excReq), .excType(excType),
    .excVector(excVector), .frameWord(frameWord), .emuMode(emuMode), .pst(pst)
  );

  typedef struct packed {
    logic       rte;
    logic       rteFs1;
    logic       bnd;
    logic       bkpt;
    logic [2:0] lvl;
    logic       eReq;
    logic [1:0] eType;
    logic [7:0] eVec;
    logic       eFs1;
    logic       eEmu;
    logic [3:0] ePst;
    logic [3:0] reqNum;
  } row_t;

  localparam int NROWS = 18;
  localparam row_t TBL [NROWS] = '{
    '{1'b0,1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b0,4'h0,4'd4},  // idle
    '{1'b0,1'b0,1'b1,1'b0,3'd3, 1'b1,2'd2,8'd27,1'b0,1'b0,4'h0,4'd10}, // R10
    '{1'b0,1'b0,1'b0,1'b1,3'd5, 1'b0,2'd0,8'd0, 1'b0,1'b0,4'h0,4'd4},  // R4
    '{1'b0,1'b0,1'b1,1'b1,3'd7, 1'b1,2'd1,8'd12,1'b0,1'b1,4'hD,4'd2},  // R2
    '{1'b0,1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b1,4'hD,4'd3},  // R3
    '{1'b0,1'b0,1'b1,1'b1,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b1,4'hD,4'd9},  // R9
    '{1'b0,1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b1,4'h0,4'd3},  // R3 end
    '{1'b0,1'b0,1'b1,1'b0,3'd2, 1'b1,2'd2,8'd26,1'b1,1'b0,4'h0,4'd5},  // R5
    '{1'b1,1'b1,1'b0,1'b0,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b1,4'hD,4'd7},  // R7
    '{1'b0,1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b1,4'hD,4'd7},
    '{1'b0,1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b1,4'hD,4'd7},
    '{1'b0,1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b1,4'h0,4'd7},
    '{1'b1,1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b0,4'h7,4'd8},  // R8
    '{1'b0,1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b0,4'h0,4'd8},
    '{1'b0,1'b0,1'b1,1'b1,3'd0, 1'b1,2'd1,8'd12,1'b0,1'b1,4'hD,4'd2},
    '{1'b0,1'b0,1'b1,1'b0,3'd1, 1'b1,2'd2,8'd25,1'b1,1'b0,4'hD,4'd5},
    '{1'b1,1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b0,4'h7,4'd8},  // R8 overrides hold
    '{1'b0,1'b0,1'b0,1'b0,3'd0, 1'b0,2'd0,8'd0, 1'b0,1'b0,4'h0,4'd8}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idleIn();
    bkptTrig = 1'b0; ipl = 3'd0; instBoundary = 1'b0;
    rteStrobe = 1'b0; rteFrame = 32'h0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idleIn();
    statusReg = 16'h2704;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 emuMode", 32'(emuMode), 32'd0);
    chk("R1 excReq", 32'(excReq), 32'd0);
    chk("R1 excType", 32'(excType), 32'd0);
    chk("R1 pst", 32'(pst), 32'd0);
    chk("R1 frameWord", frameWord, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      rteStrobe    = TBL[i].rte;
      rteFrame     = {14'h1300, TBL[i].rteFs1, 17'h02700};
      instBoundary = TBL[i].bnd;
      bkptTrig     = TBL[i].bkpt;
      ipl          = TBL[i].lvl;
      step();
      idleIn();
      chk($sformatf("R%0d row%0d excReq", TBL[i].reqNum, i), 32'(excReq), 32'(TBL[i].eReq));
      chk($sformatf("R%0d row%0d emuMode", TBL[i].reqNum, i), 32'(emuMode), 32'(TBL[i].eEmu));
      chk($sformatf("R%0d row%0d pst", TBL[i].reqNum, i), 32'(pst), 32'(TBL[i].ePst));
      if (TBL[i].eReq) begin
        chk($sformatf("R%0d row%0d excType", TBL[i].reqNum, i), 32'(excType), 32'(TBL[i].eType));
        chk($sformatf("R%0d row%0d excVector", TBL[i].reqNum, i), 32'(excVector), 32'(TBL[i].eVec));
        chk($sformatf("R%0d row%0d FS1", TBL[i].reqNum, i), 32'(frameWord[17]), 32'(TBL[i].eFs1));
      end
    end

    // R6 full header word, debug entry outside emulator mode
    statusReg = 16'hA5C3;
    instBoundary = 1'b1; bkptTrig = 1'b1;
    step();
    idleIn();
    chk("R6 debug header", frameWord, 32'h4030A5C3);
    // R6 / R5 header for a level-6 interrupt inside emulator mode
    statusReg = 16'h1234;
    instBoundary = 1'b1; ipl = 3'd6;
    step();
    idleIn();
    chk("R6 nested header", frameWord, 32'h407A1234);
    chk("R5 emuMode cleared", 32'(emuMode), 32'd0);

    // R1 reset while in emulator mode
    instBoundary = 1'b1; bkptTrig = 1'b1;
    step();
    idleIn();
    chk("R3 entry before reset", 32'(emuMode), 32'd1);
    rstN = 1'b0;
    step();
    chk("R1 reset emuMode", 32'(emuMode), 32'd0);
    chk("R1 reset pst", 32'(pst), 32'd0);
    chk("R1 reset frameWord", frameWord, 32'd0);
    rstN = 1'b1;
    step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule